// File: doc/BRIEF.md
# Differencing Multistage Interference-Cancelling Detector

This block separates the symbols of several synchronous users that share one spreading channel. Once per frame, software or an upstream estimator writes the amplitude-scaled cross-correlation matrix into the block one entry at a time. After that, each symbol arrives as a vector of matched-filter soft values, one per user. The block refines that vector through three cascaded parallel-interference-cancellation stages and then presents soft values and hard sign decisions.

The first stage removes the interference implied by the initial sign decisions. Each later stage removes only the change in interference. That change comes from users whose decisions flipped between the two most recent stages, so the differencing weights can only be 0 or ±2. Every product is therefore either skipped or replaced by a one-bit left shift followed by an add or a subtract.

The recoding of decision differences happens in the same cycle as the accumulation. One matrix column is consumed per clock for all users in parallel, so each stage takes one clock per user.

Top module: `mdpic_det`

## Requirements
- R1: A write with `ld_en` high while idle stores `ld_data` as the matrix entry at row `ld_row`, column `ld_col`. Entries persist across any number of detections until they are rewritten.
- R2: Diagonal entries (row equal to column) have no effect on any stage result.
- R3: Stage 0 result for user k equals y[k] minus the sum over j≠k of R[k][j]·d0[j]. Here y is the input soft value and d0[j] is +1 when y[j] ≥ 0 and −1 otherwise.
- R4: Stage s ≥ 1 result for user k equals the stage s−1 result minus the sum over j≠k of R[k][j]·(d_{s−1}[j] − d_{s−2}[j]), with d_{−1}=d0. When no stage saturates, the hard decisions equal those of a non-differencing cancellation y − R·d_{s−1}.
- R5: Bit k of `hard_out` is 1 when the soft value of user k is negative. It is 0 (decision +1) when that value is zero or positive.
- R6: Each stage result is clamped to the signed range −2048..2047 before it is stored or used by the next stage.
- R7: `stage_done` pulses for exactly one cycle, NUSR clocks after the accepted start edge and again every NUSR clocks, with `stage_num` = 0, 1, 2. `out_valid` pulses together with stage 2, and `busy` drops in that same cycle.
- R8: While `busy` is high, `start` and `ld_en` are ignored: the running detection and the stored matrix are unaffected.
- R9: After reset, `busy`, `stage_done`, `out_valid`, `stage_num`, `soft_out` and `hard_out` are all zero.
- R10: Soft vectors pack user k in bits [k·12 +: 12] as two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Matrix entry write strobe |
| ld_row | input | 3 | Row (victim user) of the entry |
| ld_col | input | 3 | Column (interfering user) of the entry |
| ld_data | input | 12 | Signed cross-correlation value |
| start | input | 1 | Begin detection of `soft_in` when idle |
| soft_in | input | 96 | Matched-filter soft values, 12 bits per user |
| busy | output | 1 | Detection in progress |
| stage_done | output | 1 | One-cycle pulse after each stage |
| stage_num | output | 2 | Index of the stage just finished |
| out_valid | output | 1 | One-cycle pulse after the final stage |
| soft_out | output | 96 | Soft values of the latest stage |
| hard_out | output | 8 | Sign decisions of the latest stage, 1 = negative |

## Verification
The bench sweeps every sign pattern of the eight inputs against two matrix scales. At each stage it compares soft and hard results to an arithmetic model, and to a plain non-differencing canceller whenever nothing clipped. A recoder that kept the ±1 weights after stage 0, or that forgot to skip unchanged users, would diverge from that canceller at stage 1 or 2. Zero-valued inputs catch a tie mapped to −1. A large diagonal catches a lane that fails to skip its own column. A full-scale matrix drives every stage into the clamp, so a wrapping accumulator shows up as a sign flip. Start and write attempts in mid-run would corrupt either the running result or the next frame's result if they were honoured.

// File: rtl/mdpic_pkg.sv
package mdpic_pkg;
    // Per-column recoded weight shared by all user lanes
    typedef struct packed {
        logic en;   // term contributes
        logic sub;  // subtract (1) or add (0)
        logic dbl;  // weight magnitude 2 (shift by one) instead of 1
    } mdpic_code_t;
endpackage

// File: rtl/mdpic_xmat.sv
// Cross-correlation store: NUSR x NUSR signed entries written one at a time.
// Presents one full column (entry [k][col] for every row k) per cycle.
// Assumes the caller gates writes while a detection is running.
module mdpic_xmat #(
    parameter int NUSR = 8,
    parameter int W    = 12,
    localparam int CW  = $clog2(NUSR)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [CW-1:0]        wr_row,
    input  logic [CW-1:0]        wr_col,
    input  logic [W-1:0]         wr_data,
    input  logic [CW-1:0]        rd_col,
    output logic [NUSR*W-1:0]    col_vec
);
    logic [W-1:0] mem [NUSR][NUSR];

    // Entry write
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_row][wr_col] <= wr_data;
    end

    // Column read, one entry per row
    for (genvar k = 0; k < NUSR; k++) begin : g_rd
        assign col_vec[k*W +: W] = mem[k][rd_col];
    end
endmodule

// File: rtl/mdpic_recode.sv
// Turns the two most recent decision bits of the current column user into a
// weight code: stage 0 uses +-1 from the initial decision, later stages use
// 0 or +-2 from the decision difference. Decision bit 1 means -1.
module mdpic_recode
    import mdpic_pkg::*;
#(
    parameter int NUSR = 8,
    localparam int CW  = $clog2(NUSR)
) (
    input  logic [NUSR-1:0] d_new,
    input  logic [NUSR-1:0] d_old,
    input  logic [CW-1:0]   col,
    input  logic            first,
    output mdpic_code_t     code
);
    // Weight selection for the column user
    always_comb begin
        code.en  = first | (d_new[col] ^ d_old[col]);
        code.sub = ~d_new[col];
        code.dbl = ~first;
    end
endmodule

// File: rtl/mdpic_lane.sv
// One user's accumulator. Loads its matched-filter value, then adds or
// subtracts one shifted cross-correlation term per cycle (skipping its own
// column and zero weights), and clamps/stores the result on a stage's last
// column. Assumes AW is wide enough for NUSR terms of magnitude 2^W.
module mdpic_lane
    import mdpic_pkg::*;
#(
    parameter int NUSR = 8,
    parameter int W    = 12,
    parameter int AW   = 18,
    parameter int IDX  = 0,
    localparam int CW  = $clog2(NUSR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic                last,
    input  logic [W-1:0]        y,
    input  logic [W-1:0]        rval,
    input  mdpic_code_t         code,
    input  logic [CW-1:0]       col,
    output logic                z_neg,
    output logic [W-1:0]        z_q
);
    localparam logic signed [AW-1:0] SMAX = AW'((1 << (W-1)) - 1);
    localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);

    logic signed [AW-1:0] acc, rext, term, sum;
    logic [W-1:0]         satv;
    logic                 skip;

    // Shift/sign recoded term and clamped stage result
    always_comb begin
        rext = {{(AW-W){rval[W-1]}}, rval};
        term = code.dbl ? (rext <<< 1) : rext;
        skip = !code.en || (col == CW'(IDX));
        if (skip)          sum = acc;
        else if (code.sub) sum = acc - term;
        else               sum = acc + term;
        if (sum > SMAX)      satv = SMAX[W-1:0];
        else if (sum < SMIN) satv = SMIN[W-1:0];
        else                 satv = sum[W-1:0];
    end

    assign z_neg = satv[W-1];

    // Accumulator and stored stage result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            z_q <= '0;
        end else if (load) begin
            acc <= {{(AW-W){y[W-1]}}, y};
        end else if (step) begin
            if (last) begin
                z_q <= satv;
                acc <= {{(AW-W){satv[W-1]}}, satv};
            end else begin
                acc <= sum;
            end
        end
    end

    // R2
    property p_diag;
        @(posedge clk) disable iff (!rst_n)
        (step && !last && col == CW'(IDX)) |=> $stable(acc);
    endproperty
    diag_skip_chk: assert property (p_diag);

    // R4
    property p_zero_w;
        @(posedge clk) disable iff (!rst_n)
        (step && !last && !code.en) |=> $stable(acc);
    endproperty
    zero_weight_chk: assert property (p_zero_w);
endmodule

// File: rtl/mdpic_det.sv
// Three-stage differencing parallel interference canceller for NUSR
// synchronous users. Column-serial: each stage takes NUSR clocks, all user
// lanes update in parallel. Matrix writes and starts are ignored while busy.
module mdpic_det
    import mdpic_pkg::*;
#(
    parameter int NUSR = 8,
    parameter int W    = 12,
    parameter int NSTG = 3,
    localparam int CW  = $clog2(NUSR),
    localparam int SW  = $clog2(NSTG),
    localparam int AW  = W + CW + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_en,
    input  logic [CW-1:0]       ld_row,
    input  logic [CW-1:0]       ld_col,
    input  logic [W-1:0]        ld_data,
    input  logic                start,
    input  logic [NUSR*W-1:0]   soft_in,
    output logic                busy,
    output logic                stage_done,
    output logic [SW-1:0]       stage_num,
    output logic                out_valid,
    output logic [NUSR*W-1:0]   soft_out,
    output logic [NUSR-1:0]     hard_out
);
    logic [CW-1:0]      col;
    logic [SW-1:0]      stg;
    logic               first;
    logic [NUSR-1:0]    d_new, d_old, z_neg, y_neg;
    logic [NUSR*W-1:0]  col_vec;
    logic               load, last;
    mdpic_code_t        code;

    assign load     = !busy && start;
    assign last     = busy && (col == CW'(NUSR-1));
    assign hard_out = d_new;

    mdpic_xmat #(.NUSR(NUSR), .W(W)) u_xmat (
        .clk(clk), .wr_en(ld_en && !busy), .wr_row(ld_row), .wr_col(ld_col),
        .wr_data(ld_data), .rd_col(col), .col_vec(col_vec)
    );

    mdpic_recode #(.NUSR(NUSR)) u_rec (
        .d_new(d_new), .d_old(d_old), .col(col), .first(first), .code(code)
    );

    for (genvar k = 0; k < NUSR; k++) begin : g_lane
        assign y_neg[k] = soft_in[k*W + W-1];
        mdpic_lane #(.NUSR(NUSR), .W(W), .AW(AW), .IDX(k)) u_lane (
            .clk(clk), .rst_n(rst_n), .load(load), .step(busy), .last(last),
            .y(soft_in[k*W +: W]), .rval(col_vec[k*W +: W]), .code(code),
            .col(col), .z_neg(z_neg[k]), .z_q(soft_out[k*W +: W])
        );
    end

    // Sequencer: column/stage counters and decision history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            col        <= '0;
            stg        <= '0;
            first      <= 1'b0;
            stage_done <= 1'b0;
            stage_num  <= '0;
            out_valid  <= 1'b0;
            d_new      <= '0;
            d_old      <= '0;
        end else begin
            stage_done <= 1'b0;
            out_valid  <= 1'b0;
            if (load) begin
                busy  <= 1'b1;
                col   <= '0;
                stg   <= '0;
                first <= 1'b1;
                d_new <= y_neg;
            end else if (busy) begin
                if (last) begin
                    col        <= '0;
                    first      <= 1'b0;
                    d_old      <= d_new;
                    d_new      <= z_neg;
                    stage_done <= 1'b1;
                    stage_num  <= stg;
                    if (stg == SW'(NSTG-1)) begin
                        busy      <= 1'b0;
                        out_valid <= 1'b1;
                    end else begin
                        stg <= stg + SW'(1);
                    end
                end else begin
                    col <= col + CW'(1);
                end
            end
        end
    end

    // R7
    property p_fin;
        @(posedge clk) disable iff (!rst_n)
        out_valid |-> (stage_done && stage_num == SW'(NSTG-1) && !busy);
    endproperty
    final_stage_chk: assert property (p_fin);

    // R7
    property p_pulse;
        @(posedge clk) disable iff (!rst_n)
        stage_done |=> !stage_done;
    endproperty
    done_pulse_chk: assert property (p_pulse);

    // R8
    property p_busy_hold;
        @(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy;
    endproperty
    busy_hold_chk: assert property (p_busy_hold);

    // R5
    for (genvar k = 0; k < NUSR; k++) begin : g_sgn
        property p_sign;
            @(posedge clk) disable iff (!rst_n)
            stage_done |-> (hard_out[k] == soft_out[k*W + W-1]);
        endproperty
        hard_sign_chk: assert property (p_sign);
    end
endmodule

// File: tb/mdpic_det_bench.sv
`timescale 1ns/1ps
module mdpic_det_bench;
    localparam int N = 8;
    localparam int W = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ld_en = 1'b0, start = 1'b0;
    logic [2:0] ld_row = '0, ld_col = '0;
    logic [W-1:0] ld_data = '0;
    logic [N*W-1:0] soft_in = '0;
    logic busy, stage_done, out_valid;
    logic [1:0] stage_num;
    logic [N*W-1:0] soft_out;
    logic [N-1:0] hard_out;

    int checks = 0, fails = 0;
    int unsigned seed = 32'h1234_5678;
    int rm [N][N];
    int ys [N];
    int ez [3][N];
    bit [N-1:0] eh [3];
    bit [N-1:0] ch [3];
    bit nosat [3];

    always #10 clk = ~clk;

    mdpic_det u_mdpic_det (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row), .ld_col(ld_col),
        .ld_data(ld_data), .start(start), .soft_in(soft_in), .busy(busy),
        .stage_done(stage_done), .stage_num(stage_num), .out_valid(out_valid),
        .soft_out(soft_out), .hard_out(hard_out)
    );

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    function automatic int clamp(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [N*W-1:0] got, input logic [N*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Differencing model with clamping, plus a plain canceller for comparison
    task automatic model();
        int z [N]; int zn [N]; int dp [N]; int dq [N]; int cd [N]; int cn [N];
        int acc; bit sat_any;
        sat_any = 0;
        for (int k = 0; k < N; k++) begin
            z[k] = ys[k]; dp[k] = (ys[k] < 0) ? -1 : 1; dq[k] = 0; cd[k] = dp[k];
        end
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < N; k++) begin
                acc = z[k];
                for (int j = 0; j < N; j++)
                    if (j != k) acc -= rm[k][j] * ((s == 0) ? dp[j] : (dp[j] - dq[j]));
                if (acc > 2047 || acc < -2048) sat_any = 1;
                zn[k] = clamp(acc);
                acc = ys[k];
                for (int j = 0; j < N; j++) if (j != k) acc -= rm[k][j] * cd[j];
                cn[k] = (acc < 0) ? -1 : 1;
                ch[s][k] = (acc < 0);
            end
            for (int k = 0; k < N; k++) begin
                dq[k] = dp[k]; dp[k] = (zn[k] < 0) ? -1 : 1; z[k] = zn[k];
                ez[s][k] = zn[k]; eh[s][k] = (zn[k] < 0); cd[k] = cn[k];
            end
            nosat[s] = !sat_any;
        end
    endtask

    task automatic load_all();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                @(negedge clk);
                ld_en = 1'b1; ld_row = 3'(r); ld_col = 3'(c); ld_data = W'(rm[r][c]);
            end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // One detection with per-cycle timing and per-stage result checks
    task automatic run_det(input string tag, input bit disturb);
        logic [N*W-1:0] es;
        for (int k = 0; k < N; k++) soft_in[k*W +: W] = W'(ys[k]);
        model();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= 3*N; i++) begin
            @(negedge clk);
            if (disturb && i == 1) begin   // R8: mid-run start and write
                start = 1'b1; soft_in = ~soft_in;
                ld_en = 1'b1; ld_row = 3'd0; ld_col = 3'd1; ld_data = 12'h3e7;
            end else if (disturb && i == 2) begin
                start = 1'b0; ld_en = 1'b0;
            end
            if (i % N == 0) begin
                int s = i / N - 1;
                for (int k = 0; k < N; k++) es[k*W +: W] = W'(ez[s][k]);
                chk(stage_done === 1'b1 && stage_num === 2'(s), "R7", "stage pulse",
                    {94'd0, stage_num}, 96'(s));
                chk(out_valid === (s == 2) && busy === (s != 2), "R7", "valid/busy",
                    {94'd0, out_valid, busy}, {94'd0, s == 2, s != 2});
                chk(soft_out === es, tag, $sformatf("stage %0d soft", s), soft_out, es);
                chk(hard_out === eh[s], tag, $sformatf("stage %0d hard", s),
                    {88'd0, hard_out}, {88'd0, eh[s]});
                if (nosat[s])
                    chk(hard_out === ch[s], "R4", $sformatf("stage %0d vs plain PIC", s),
                        {88'd0, hard_out}, {88'd0, ch[s]});
            end else if (stage_done !== 1'b0 || busy !== 1'b1) begin
                chk(1'b0, "R7", "early pulse or idle", {94'd0, stage_done, busy}, 96'd1);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, stage_done, out_valid, stage_num, soft_out, hard_out} === '0,
            "R9", "reset state", soft_out, '0);

        // R1 R3 R4 R5 R6 R10: every sign pattern, two matrix scales
        for (int m = 0; m < 2; m++) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    rm[r][c] = int'(rnd() % (m == 0 ? 127 : 801)) - (m == 0 ? 63 : 400);
            load_all();
            for (int p = 0; p < 256; p++) begin
                for (int k = 0; k < N; k++)
                    ys[k] = (((p >> k) & 1) != 0 ? -1 : 1) * int'(1 + rnd() % 1200);
                run_det("R1/R3/R4/R10", 1'b0);
            end
        end

        // R5: all-zero inputs decide +1
        for (int k = 0; k < N; k++) ys[k] = 0;
        run_det("R5", 1'b0);

        // R2: large diagonal must not matter
        for (int k = 0; k < N; k++) rm[k][k] = 2047;
        load_all();
        for (int p = 0; p < 16; p++) begin
            for (int k = 0; k < N; k++) ys[k] = int'(rnd() % 3000) - 1500;
            run_det("R2", 1'b0);
        end

        // R8: mid-run start/write ignored, matrix still intact afterwards
        run_det("R8", 1'b1);
        run_det("R8", 1'b0);

        // R6: full-scale matrix forces clamping
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) rm[r][c] = (r == c) ? 0 : 2047;
        load_all();
        for (int k = 0; k < N; k++) ys[k] = 100;
        run_det("R6", 1'b0);
        for (int k = 0; k < N; k++) ys[k] = (k < 3) ? -2048 : 2047;
        run_det("R6", 1'b0);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) rm[r][c] = (r == c) ? 0 : -2048;
        load_all();
        for (int k = 0; k < N; k++) ys[k] = (k % 2 == 0) ? 5 : -5;
        run_det("R6", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule